// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block lives in a microcontroller's special-function-register space and performs single-byte operations on an on-chip non-volatile byte store. Software sets the enable bit, selects an operation mode and loads a 16-bit byte address from two address registers. It then writes a two-byte unlock key to the command register. When the key completes in the right order, the controller starts the selected operation and holds the CPU stalled until the operation is finished.

Three operations are supported: byte read into the data register, byte program from the data register, and erase of the page that contains the address. Program and erase are allowed only inside a configurable window of addresses. An attempt outside that window is dropped and sets a sticky fail flag, but the stall still runs for its full length. The store is a behavioural byte array with a fixed per-operation latency, and it is loaded with a known pattern at reset.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, every register reads 00h, `cpuStall` and `failFlag` are low, and store byte i holds (i mod 256) XOR 5Ah.
- R2: `sfrSel` selects a register: 0 control (bit 7 = enable), 1 mode, 2 address high, 3 address low, 4 data, 5 command (reads 00h), 6 status (bit 0 = fail, bit 1 = busy). The control, mode, address and data registers read back the value last written to them.
- R3: An operation is launched only when a command write of 46h is followed by a command write of B9h. Writes to other registers between the two key writes do not break the sequence. Any command write that is not the expected next key value clears the detector and launches nothing.
- R4: `cpuStall` rises in the cycle after the B9h write and stays high for exactly RD_LAT, PG_LAT or ER_LAT cycles for read, program or erase.
- R5: With mode 01h, when the stall ends the data register holds the store byte indexed by the low MEM_AW bits of {address high, address low}.
- R6: If the enable bit is 0 when the key completes, or the mode is 00h (standby) or any value above 03h, there is no stall and no access to the store or the data register.
- R7: With mode 02h, a target address in [WR_LO, WR_HI] has its byte overwritten with the data register value.
- R8: With mode 03h, all 2^PAGE_W bytes of the aligned page that holds the address are set to FFh, provided the whole page lies in [WR_LO, WR_HI].
- R9: A program or erase outside the permitted window leaves the store unchanged, still stalls for its full latency, and sets the fail flag. The fail flag stays set until software writes status with bit 0 = 1.
- R10: While the stall is asserted, all register writes are ignored and status bit 1 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWe | input | 1 | Register write strobe |
| sfrSel | input | 3 | Register select |
| sfrWdata | input | 8 | Register write data |
| sfrRdata | output | 8 | Register read data for the selected register (combinational) |
| cpuStall | output | 1 | Holds the CPU while an operation runs |
| failFlag | output | 1 | Sticky out-of-window program/erase flag |

## Verification
The bench builds the controller with short latencies (read 2, program 5, erase 9) so that each stall can be counted cycle by cycle. It uses a 256-byte store, which lets it fold a 16-bit address with a nonzero high byte back into the store. Pages are 8 bytes and the window is 40h to BFh, so a single erase can be checked at both page edges and at the first byte past the page. With those values, an erase just above the window and a program just below it are both easy to reach.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADRH   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ADRL   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CMD    = 3'd5;
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd6;

  localparam logic [7:0] MODE_STBY  = 8'h00;
  localparam logic [7:0] MODE_READ  = 8'h01;
  localparam logic [7:0] MODE_PROG  = 8'h02;
  localparam logic [7:0] MODE_ERASE = 8'h03;

  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'hB9;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} fcmdOp_t;

  typedef struct packed {
    logic doRead;
    logic doProg;
    logic doErase;
  } fcmdStrobe_t;
endpackage

// File: rtl/fcmd_ctrl_fsm.sv
module fcmd_ctrl_fsm
  import fcmd_pkg::*;
#(
  parameter int RD_LAT = 3,
  parameter int PG_LAT = 7,
  parameter int ER_LAT = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic [7:0]  cmdData,
  input  logic        enable,
  input  logic [7:0]  mode,
  output fcmdStrobe_t strobe,
  output logic        busy
);
  localparam int MAX_PE  = (ER_LAT > PG_LAT) ? ER_LAT : PG_LAT;
  localparam int MAX_LAT = (MAX_PE > RD_LAT) ? MAX_PE : RD_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  fcmdOp_t          opState;
  fcmdOp_t          reqOp;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             keyArmed;
  logic             keyDone;
  logic             launch;
  logic             lastCycle;

  // Decode the requested operation and its stall length
  always_comb begin
    reqOp   = OP_NONE;
    loadVal = '0;
    case (mode)
      MODE_READ:  begin reqOp = OP_READ;  loadVal = CNT_W'(RD_LAT - 1); end
      MODE_PROG:  begin reqOp = OP_PROG;  loadVal = CNT_W'(PG_LAT - 1); end
      MODE_ERASE: begin reqOp = OP_ERASE; loadVal = CNT_W'(ER_LAT - 1); end
      default:    begin reqOp = OP_NONE;  loadVal = '0; end
    endcase
  end

  assign keyDone   = cmdWe && keyArmed && (cmdData == KEY_SECOND);
  assign launch    = keyDone && enable && (reqOp != OP_NONE);
  assign busy      = (opState != OP_NONE);
  assign lastCycle = busy && (cnt == '0);

  // Key detector: armed only by a first-key write; any command write re-evaluates
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyArmed <= 1'b0;
    end else if (cmdWe) begin
      keyArmed <= !keyArmed && (cmdData == KEY_FIRST);
    end
  end

  // Operation sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opState <= OP_NONE;
      cnt     <= '0;
    end else if (launch) begin
      opState <= reqOp;
      cnt     <= loadVal;
    end else if (lastCycle) begin
      opState <= OP_NONE;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.doRead  = lastCycle && (opState == OP_READ);
    strobe.doProg  = lastCycle && (opState == OP_PROG);
    strobe.doErase = lastCycle && (opState == OP_ERASE);
  end

  // R6: a completed key with the controller disabled must not start anything
  p_no_launch_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (keyDone && !enable) |=> !busy);

  // R3: a wrong command value never leaves the detector armed
  p_bad_key_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdData != KEY_FIRST) |=> !keyArmed);

  // R4: while counting, the running operation does not change
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && $stable(opState)));
endmodule

// File: rtl/fcmd_datapath.sv
module fcmd_datapath
  import fcmd_pkg::*;
#(
  parameter int          MEM_AW = 8,
  parameter int          PAGE_W = 4,
  parameter logic [15:0] WR_LO  = 16'h0040,
  parameter logic [15:0] WR_HI  = 16'h00BF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sfrWe,
  input  logic [SEL_W-1:0] sfrSel,
  input  logic [7:0]       sfrWdata,
  input  logic             busy,
  input  fcmdStrobe_t      strobe,
  output logic [7:0]       sfrRdata,
  output logic             cmdWe,
  output logic [7:0]       cmdData,
  output logic             enable,
  output logic [7:0]       mode,
  output logic             failFlag
);
  localparam int          DEPTH     = 1 << MEM_AW;
  localparam logic [15:0] PAGE_MASK = 16'((1 << PAGE_W) - 1);

  logic [7:0] ctrlReg, modeReg, adrHi, adrLo, dataReg;
  logic       failReg;
  logic [7:0] mem [DEPTH];

  logic [15:0]       addr16;
  logic [MEM_AW-1:0] memIdx;
  logic [15:0]       pageBase, pageEnd;
  logic              progOk, eraseOk;
  logic              wrEn, failClr;

  assign addr16   = {adrHi, adrLo};
  assign memIdx   = addr16[MEM_AW-1:0];
  assign pageBase = addr16 & ~PAGE_MASK;
  assign pageEnd  = addr16 | PAGE_MASK;
  assign progOk   = (addr16 >= WR_LO) && (addr16 <= WR_HI);
  assign eraseOk  = (pageBase >= WR_LO) && (pageEnd <= WR_HI);

  assign wrEn    = sfrWe && !busy;
  assign cmdWe   = wrEn && (sfrSel == SEL_CMD);
  assign cmdData = sfrWdata;
  assign failClr = wrEn && (sfrSel == SEL_STATUS) && sfrWdata[0];
  assign enable  = ctrlReg[7];
  assign mode    = modeReg;
  assign failFlag = failReg;

  // Software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= '0;
      adrHi   <= '0;
      adrLo   <= '0;
    end else if (wrEn) begin
      case (sfrSel)
        SEL_CTRL: ctrlReg <= sfrWdata;
        SEL_MODE: modeReg <= sfrWdata;
        SEL_ADRH: adrHi   <= sfrWdata;
        SEL_ADRL: adrLo   <= sfrWdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.doRead) begin
      dataReg <= mem[memIdx];
    end else if (wrEn && sfrSel == SEL_DATA) begin
      dataReg <= sfrWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failReg <= 1'b0;
    end else if ((strobe.doProg && !progOk) || (strobe.doErase && !eraseOk)) begin
      failReg <= 1'b1;
    end else if (failClr) begin
      failReg <= 1'b0;
    end
  end

  // Behavioural byte store: reset pattern, byte program, page erase
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        mem[i] <= 8'(i) ^ 8'h5A;
      end else if (strobe.doErase && eraseOk &&
                   ((MEM_AW'(i) >> PAGE_W) == (memIdx >> PAGE_W))) begin
        mem[i] <= 8'hFF;
      end else if (strobe.doProg && progOk && (MEM_AW'(i) == memIdx)) begin
        mem[i] <= dataReg;
      end
    end
  end

  always_comb begin
    case (sfrSel)
      SEL_CTRL:   sfrRdata = ctrlReg;
      SEL_MODE:   sfrRdata = modeReg;
      SEL_ADRH:   sfrRdata = adrHi;
      SEL_ADRL:   sfrRdata = adrLo;
      SEL_DATA:   sfrRdata = dataReg;
      SEL_STATUS: sfrRdata = {6'b0, busy, failReg};
      default:    sfrRdata = 8'h00;
    endcase
  end

  // R4: the sequencer finishes at most one operation per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doRead, strobe.doProg, strobe.doErase}));

  // R9: an out-of-window program raises the fail flag
  p_fail_on_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doProg && !progOk) |=> failFlag);

  // R9: the fail flag only drops through a status clear
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !failClr) |=> failFlag);

  // R10: operands are frozen while an operation runs
  p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(adrHi) && $stable(adrLo) && $stable(modeReg)));
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int          RD_LAT = 3,
  parameter int          PG_LAT = 7,
  parameter int          ER_LAT = 12,
  parameter int          MEM_AW = 8,
  parameter int          PAGE_W = 4,
  parameter logic [15:0] WR_LO  = 16'h0040,
  parameter logic [15:0] WR_HI  = 16'h00BF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWe,
  input  logic [2:0] sfrSel,
  input  logic [7:0] sfrWdata,
  output logic [7:0] sfrRdata,
  output logic       cpuStall,
  output logic       failFlag
);
  fcmdStrobe_t strobe;
  logic        busy;
  logic        cmdWe;
  logic [7:0]  cmdData;
  logic        enable;
  logic [7:0]  mode;

  fcmd_ctrl_fsm #(
    .RD_LAT(RD_LAT), .PG_LAT(PG_LAT), .ER_LAT(ER_LAT)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData),
    .enable(enable), .mode(mode), .strobe(strobe), .busy(busy)
  );

  fcmd_datapath #(
    .MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .WR_LO(WR_LO), .WR_HI(WR_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrSel(sfrSel),
    .sfrWdata(sfrWdata), .busy(busy), .strobe(strobe),
    .sfrRdata(sfrRdata), .cmdWe(cmdWe), .cmdData(cmdData),
    .enable(enable), .mode(mode), .failFlag(failFlag)
  );

  assign cpuStall = busy;

  // R4: the stall can only start right after a second-key command write
  p_stall_after_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |-> $past(sfrWe && sfrSel == SEL_CMD && sfrWdata == KEY_SECOND));
endmodule

// File: tb/fcmd_ctrl_bench.sv
module fcmd_ctrl_bench;
  import fcmd_pkg::*;

  localparam int          RD_LAT = 2;
  localparam int          PG_LAT = 5;
  localparam int          ER_LAT = 9;
  localparam int          MEM_AW = 8;
  localparam int          PAGE_W = 3;
  localparam logic [15:0] WR_LO  = 16'h0040;
  localparam logic [15:0] WR_HI  = 16'h00BF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWe = 1'b0;
  logic [2:0] sfrSel = '0;
  logic [7:0] sfrWdata = '0;
  logic [7:0] sfrRdata;
  logic       cpuStall;
  logic       failFlag;

  fcmd_ctrl #(
    .RD_LAT(RD_LAT), .PG_LAT(PG_LAT), .ER_LAT(ER_LAT),
    .MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .WR_LO(WR_LO), .WR_HI(WR_HI)
  ) u_fcmd_ctrl (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrSel(sfrSel),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata),
    .cpuStall(cpuStall), .failFlag(failFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int expStall[$];
  int runLen = 0;
  logic [7:0] model [256];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    sfrWe = 1'b1; sfrSel = sel; sfrWdata = d;
    @(negedge clk);
    sfrWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] v);
    @(negedge clk);
    sfrSel = sel;
    #1 v = sfrRdata;
  endtask

  task automatic waitIdle();
    while (cpuStall) @(negedge clk);
  endtask

  task automatic runOp(input logic [7:0] m, input logic [15:0] a, input int lat);
    wr(SEL_MODE, m);
    wr(SEL_ADRH, a[15:8]);
    wr(SEL_ADRL, a[7:0]);
    wr(SEL_CMD, KEY_FIRST);
    if (lat > 0) expStall.push_back(lat);
    wr(SEL_CMD, KEY_SECOND);
    waitIdle();
  endtask

  task automatic readByte(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    runOp(MODE_READ, a, RD_LAT);
    rd(SEL_DATA, v);
    check(req, v, exp);
  endtask

  // Monitor: pops the expected stall length when each stall pulse ends
  always @(negedge clk) begin
    if (rstN) begin
      if (cpuStall) runLen++;
      else if (runLen != 0) begin
        if (expStall.size() == 0) check("R6 unexpected stall", runLen, 0);
        else check("R4 stall length", runLen, expStall.pop_front());
        runLen = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 stall at reset", cpuStall, 1'b0);
    check("R1 fail at reset", failFlag, 1'b0);

    // R2 readback
    wr(SEL_CTRL, 8'h80); rd(SEL_CTRL, v); check("R2 control", v, 8'h80);
    wr(SEL_MODE, 8'h03); rd(SEL_MODE, v); check("R2 mode", v, 8'h03);
    wr(SEL_ADRH, 8'hC4); rd(SEL_ADRH, v); check("R2 addr high", v, 8'hC4);
    wr(SEL_ADRL, 8'h2B); rd(SEL_ADRL, v); check("R2 addr low", v, 8'h2B);
    wr(SEL_DATA, 8'h6E); rd(SEL_DATA, v); check("R2 data", v, 8'h6E);
    rd(SEL_CMD, v); check("R2 command reads zero", v, 8'h00);

    // R1/R5 reads of reset pattern, including high-address folding
    readByte("R1 reset memory", 16'h0010, model[8'h10]);
    readByte("R5 read", 16'h0091, model[8'h91]);
    readByte("R5 high bits folded", 16'h12FF, model[8'hFF]);

    // R7 program in window
    wr(SEL_DATA, 8'h3C);
    runOp(MODE_PROG, 16'h0050, PG_LAT);
    model[8'h50] = 8'h3C;
    readByte("R7 program", 16'h0050, 8'h3C);
    check("R7 no fail", failFlag, 1'b0);

    // R9 out-of-window program
    wr(SEL_DATA, 8'h77);
    runOp(MODE_PROG, 16'h0030, PG_LAT);
    check("R9 fail set", failFlag, 1'b1);
    rd(SEL_STATUS, v); check("R9 status fail bit", v, 8'h01);
    readByte("R9 byte untouched", 16'h0030, model[8'h30]);
    wr(SEL_DATA, 8'h11);
    runOp(MODE_PROG, 16'h0051, PG_LAT);
    model[8'h51] = 8'h11;
    check("R9 sticky", failFlag, 1'b1);
    wr(SEL_STATUS, 8'h01);
    check("R9 clear", failFlag, 1'b0);

    // R8 page erase (page 60h..67h)
    runOp(MODE_ERASE, 16'h0063, ER_LAT);
    for (int i = 8'h60; i < 8'h68; i++) model[i] = 8'hFF;
    readByte("R8 page start", 16'h0060, 8'hFF);
    readByte("R8 page end", 16'h0067, 8'hFF);
    readByte("R8 next page kept", 16'h0068, model[8'h68]);
    check("R8 no fail", failFlag, 1'b0);

    // R9 out-of-window erase (page C0h..C7h)
    runOp(MODE_ERASE, 16'h00C2, ER_LAT);
    check("R9 erase fail", failFlag, 1'b1);
    readByte("R9 erase suppressed", 16'h00C2, model[8'hC2]);
    wr(SEL_STATUS, 8'h01);

    // R6 disabled, standby, invalid mode
    wr(SEL_CTRL, 8'h00);
    wr(SEL_DATA, 8'hEE);
    runOp(MODE_READ, 16'h0010, 0);
    check("R6 disabled no stall", cpuStall, 1'b0);
    rd(SEL_DATA, v); check("R6 disabled no read", v, 8'hEE);
    runOp(MODE_PROG, 16'h0052, 0);
    wr(SEL_CTRL, 8'h80);
    wr(SEL_DATA, 8'hEE);
    runOp(MODE_STBY, 16'h0010, 0);
    rd(SEL_DATA, v); check("R6 standby no read", v, 8'hEE);
    runOp(8'h05, 16'h0010, 0);
    rd(SEL_DATA, v); check("R6 invalid mode no read", v, 8'hEE);
    readByte("R6 disabled program no write", 16'h0052, model[8'h52]);

    // R3 key sequence
    wr(SEL_DATA, 8'hEE);
    wr(SEL_MODE, MODE_READ); wr(SEL_ADRH, 8'h00); wr(SEL_ADRL, 8'h10);
    wr(SEL_CMD, KEY_FIRST); wr(SEL_CMD, 8'h00); wr(SEL_CMD, KEY_SECOND);
    repeat (3) @(negedge clk);
    rd(SEL_DATA, v); check("R3 broken key ignored", v, 8'hEE);
    wr(SEL_CMD, KEY_FIRST); wr(SEL_CMD, KEY_FIRST); wr(SEL_CMD, KEY_SECOND);
    repeat (3) @(negedge clk);
    rd(SEL_DATA, v); check("R3 repeated first key ignored", v, 8'hEE);
    wr(SEL_CMD, KEY_FIRST);
    wr(SEL_ADRL, 8'h11);
    expStall.push_back(RD_LAT);
    wr(SEL_CMD, KEY_SECOND);
    waitIdle();
    rd(SEL_DATA, v); check("R3 interleaved write keeps key", v, model[8'h11]);

    // R10 writes during a stall are ignored
    wr(SEL_DATA, 8'h99);
    wr(SEL_MODE, MODE_PROG); wr(SEL_ADRL, 8'h55);
    wr(SEL_CMD, KEY_FIRST);
    expStall.push_back(PG_LAT);
    wr(SEL_CMD, KEY_SECOND);
    rd(SEL_STATUS, v); check("R10 busy bit", v, 8'h02);
    wr(SEL_DATA, 8'h00);
    wr(SEL_ADRL, 8'h56);
    waitIdle();
    model[8'h55] = 8'h99;
    rd(SEL_ADRL, v); check("R10 address write ignored", v, 8'h55);
    readByte("R10 data write ignored", 16'h0055, 8'h99);
    readByte("R10 neighbour untouched", 16'h0056, model[8'h56]);

    repeat (5) @(negedge clk);
    check("R4 all expected stalls seen", expStall.size(), 0);
    finishRun();
  end
endmodule